// File: doc/BRIEF.md
# Multi-Mode Up/Down Timer Unit

A 16-bit core counter that advances in one of four selectable ways. It can count a divided system clock. It can count that divided clock only while an input pin is high. It can count edges on that pin. It can decode a pair of quadrature signals. Each step moves the count by one, up or down. The direction comes from a configuration bit, from an external pin, or, in quadrature mode, from the phase order of the two inputs.

When the count passes from all ones to zero, or from zero to all ones, an output latch flips and a one-cycle interrupt request is raised. An auxiliary register works alongside the counter in one of two ways. It can load its value into the counter whenever the counter wraps. It can also take a snapshot of the counter on a chosen edge of a separate capture pin. Software can write both the counter and the auxiliary register, and such a write overrides any hardware update in the same cycle.

All control inputs are plain level signals; the block has no streaming data path, so it has no valid/ready handshake. Every external pin passes through a two-stage synchronizer and an edge register. Its effect therefore reaches the counter on the third rising clock edge after the pin changes.

Top module: `gp_timer_unit`

## Requirements
- R1: While reset is asserted, core_q, aux_q, tgl_out and irq are all zero.
- R2: With cfg_mode = 0 (timer) and cfg_run high, the counter steps once every 2^(3+cfg_pre) clock cycles. The divider restarts from zero whenever cfg_run is low, so the first step lands on the 2^(3+cfg_pre)-th rising edge after cfg_run rises.
- R3: With cfg_mode = 1 (gated), the counter steps on divided-clock ticks only while the synchronized pin_tin is high.
- R4: With cfg_mode = 2 (event), the counter steps on pin_tin edges chosen by cfg_edge. Bit 0 selects rising edges and bit 1 selects falling edges, so 11 counts both edges and 00 counts none.
- R5: The counter counts down when the effective direction is 1. In timer, gated and event modes, the effective direction is pin_dir when cfg_ext_dir_en is 1 and cfg_dir_down otherwise.
- R6: Counting up from 0xFFFF gives 0x0000, and counting down from 0x0000 gives 0xFFFF. Each such wrap flips tgl_out and drives irq high for exactly the following cycle.
- R7: With cfg_mode = 3 (quadrature), pin_tin is phase A and pin_dir is phase B. A change of exactly one phase moves the count by one. The count goes up when the new A differs from the old B (sequence 00,10,11,01 in AB order), and cfg_dir_down inverts this. A change of both phases at once is ignored.
- R8: With cfg_aux_mode = 01 (reload), a wrap loads aux_q into the counter instead of the wrapped value.
- R9: With cfg_aux_mode = 10 (capture), aux_q takes the counter value on pin_cap edges chosen by cfg_cap_edge, using the same encoding as cfg_edge. Capture happens whether or not cfg_run is high.
- R10: wr_core_en loads wr_core_data into the counter, and wr_aux_en loads wr_aux_data into aux_q. Each overrides a step, reload or capture in the same cycle, and a wrap that is overridden raises no irq.
- R11: With cfg_run low, the counter only changes through wr_core_en.
- R12: A pin edge affects the count on the third rising clock edge after the pin changes, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_run | input | 1 | Counting enable; low also clears the divider |
| cfg_mode | input | 2 | 0 timer, 1 gated, 2 event, 3 quadrature |
| cfg_pre | input | 3 | Divider exponent minus 3 (divide by 8 up to 1024) |
| cfg_dir_down | input | 1 | Software direction, 1 = down; inverts phase direction in quadrature |
| cfg_ext_dir_en | input | 1 | Take direction from pin_dir |
| cfg_edge | input | 2 | Event edge select: bit 0 rising, bit 1 falling |
| cfg_aux_mode | input | 2 | 00 idle, 01 reload, 10 capture, 11 idle |
| cfg_cap_edge | input | 2 | Capture edge select, same encoding as cfg_edge |
| wr_core_en | input | 1 | Write strobe for the counter |
| wr_core_data | input | 16 | Counter write value |
| wr_aux_en | input | 1 | Write strobe for the auxiliary register |
| wr_aux_data | input | 16 | Auxiliary write value |
| pin_tin | input | 1 | Gate, event source or quadrature phase A |
| pin_dir | input | 1 | Direction pin or quadrature phase B |
| pin_cap | input | 1 | Capture trigger pin |
| core_q | output | 16 | Counter value |
| aux_q | output | 16 | Auxiliary register value |
| tgl_out | output | 1 | Wrap toggle latch |
| irq | output | 1 | One-cycle wrap interrupt request |

## Verification
A wrong divider state or a lost synchronizer stage shifts the cycle in which core_q moves. The bench samples exactly one cycle before and exactly at the predicted edge, so such a fault appears within a single divider period. A corrupted direction or quadrature decision pushes core_q the wrong way. Underflow and double-transition cases are chosen so that any false step lands on a visibly different value, and a bad wrap is visible at once on tgl_out and irq. A faulty auxiliary path shows in aux_q or in the value loaded after the next wrap.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    MODE_TIMER = 2'd0,
    MODE_GATED = 2'd1,
    MODE_EVENT = 2'd2,
    MODE_QUAD  = 2'd3
  } tmr_mode_e;

  typedef enum logic [1:0] {
    AUX_IDLE    = 2'd0,
    AUX_RELOAD  = 2'd1,
    AUX_CAPTURE = 2'd2,
    AUX_SPARE   = 2'd3
  } aux_mode_e;

  // sel[0] picks rising, sel[1] picks falling; chg marks a change this cycle
  function automatic logic edge_hit(input logic [1:0] sel, input logic level,
                                    input logic chg);
    return chg & ((sel[0] & level) | (sel[1] & ~level));
  endfunction

endpackage

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic level,
  output logic chg
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];
  assign chg   = sync_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W     = 3,
  parameter int MIN_SHIFT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PRE_W-1:0] pre,
  output logic             tick
);
  localparam int CNT_W = MIN_SHIFT + (1 << PRE_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  int unsigned      shamt;

  always_comb begin
    shamt = MIN_SHIFT + int'(pre);
    mask  = ~({CNT_W{1'b1}} << shamt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + 1'b1;
    else          cnt_q <= '0;
  end

  assign tick = run && ((cnt_q & mask) == mask);
endmodule

// File: rtl/tmr_quad_dec.sv
module tmr_quad_dec (
  input  logic a,
  input  logic a_chg,
  input  logic b,
  input  logic b_chg,
  output logic step,
  output logic up
);
  logic b_old;

  always_comb begin
    b_old = b ^ b_chg;
    step  = a_chg ^ b_chg;
    up    = a ^ b_old;
  end
endmodule

// File: rtl/gp_timer_unit.sv
module gp_timer_unit
  import tmr_pkg::*;
#(
  parameter int W           = 16,
  parameter int PRE_W       = 3,
  parameter int MIN_SHIFT   = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_run,
  input  logic [1:0]       cfg_mode,
  input  logic [PRE_W-1:0] cfg_pre,
  input  logic             cfg_dir_down,
  input  logic             cfg_ext_dir_en,
  input  logic [1:0]       cfg_edge,
  input  logic [1:0]       cfg_aux_mode,
  input  logic [1:0]       cfg_cap_edge,
  input  logic             wr_core_en,
  input  logic [W-1:0]     wr_core_data,
  input  logic             wr_aux_en,
  input  logic [W-1:0]     wr_aux_data,
  input  logic             pin_tin,
  input  logic             pin_dir,
  input  logic             pin_cap,
  output logic [W-1:0]     core_q,
  output logic [W-1:0]     aux_q,
  output logic             tgl_out,
  output logic             irq
);
  localparam int NPIN = 3;
  localparam int P_TIN = 0;
  localparam int P_DIR = 1;
  localparam int P_CAP = 2;

  logic [NPIN-1:0] pins_raw, pin_lvl, pin_chg;
  logic            tick, q_step, q_up;
  logic            step, dir_down, wrap, capture;
  logic [W-1:0]    core_next;
  tmr_mode_e       mode;
  aux_mode_e       aux_mode;

  assign pins_raw = {pin_cap, pin_dir, pin_tin};
  assign mode     = tmr_mode_e'(cfg_mode);
  assign aux_mode = aux_mode_e'(cfg_aux_mode);

  for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
    tmr_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (pins_raw[gi]),
      .level(pin_lvl[gi]),
      .chg  (pin_chg[gi])
    );
  end

  tmr_prescaler #(.PRE_W(PRE_W), .MIN_SHIFT(MIN_SHIFT)) i_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (cfg_run),
    .pre  (cfg_pre),
    .tick (tick)
  );

  tmr_quad_dec i_quad (
    .a    (pin_lvl[P_TIN]),
    .a_chg(pin_chg[P_TIN]),
    .b    (pin_lvl[P_DIR]),
    .b_chg(pin_chg[P_DIR]),
    .step (q_step),
    .up   (q_up)
  );

  always_comb begin
    dir_down = cfg_ext_dir_en ? pin_lvl[P_DIR] : cfg_dir_down;
    unique case (mode)
      MODE_TIMER: step = tick;
      MODE_GATED: step = tick & pin_lvl[P_TIN];
      MODE_EVENT: step = edge_hit(cfg_edge, pin_lvl[P_TIN], pin_chg[P_TIN]);
      MODE_QUAD: begin
        step     = q_step;
        dir_down = ~q_up ^ cfg_dir_down;
      end
      default:    step = 1'b0;
    endcase
    step = step & cfg_run;

    wrap = step && (dir_down ? (core_q == '0) : (core_q == '1));
    if (wrap && aux_mode == AUX_RELOAD) core_next = aux_q;
    else if (dir_down)                  core_next = core_q - 1'b1;
    else                                core_next = core_q + 1'b1;

    capture = (aux_mode == AUX_CAPTURE) &&
              edge_hit(cfg_cap_edge, pin_lvl[P_CAP], pin_chg[P_CAP]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q  <= '0;
      tgl_out <= 1'b0;
      irq     <= 1'b0;
    end else begin
      irq <= wrap && !wr_core_en;
      if (wr_core_en) begin
        core_q <= wr_core_data;
      end else if (step) begin
        core_q <= core_next;
        if (wrap) tgl_out <= ~tgl_out;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         aux_q <= '0;
    else if (wr_aux_en) aux_q <= wr_aux_data;
    else if (capture)   aux_q <= core_q;
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cfg_run,
  input logic [1:0]   cfg_aux_mode,
  input logic         wr_core_en,
  input logic [W-1:0] wr_core_data,
  input logic         wr_aux_en,
  input logic [W-1:0] wr_aux_data,
  input logic [W-1:0] core_q,
  input logic [W-1:0] aux_q,
  input logic         tgl_out,
  input logic         irq
);
  AST_CORE_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_core_en |=> core_q == $past(wr_core_data)); // R10

  AST_AUX_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_aux_en |=> aux_q == $past(wr_aux_data)); // R10

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_run && !wr_core_en) |=> $stable(core_q)); // R11

  AST_STOPPED_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_run || wr_core_en) |=> !irq); // R6

  AST_IRQ_WITH_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> tgl_out != $past(tgl_out)); // R6

  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_core_en && cfg_aux_mode != 2'b01) |=>
      (core_q == $past(core_q) || core_q == $past(core_q) + W'(1) ||
       core_q == $past(core_q) - W'(1))); // R8

  always_comb begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (core_q == '0 && aux_q == '0 && !tgl_out && !irq); // R1
    end
  end
endmodule

bind gp_timer_unit tmr_checker #(.W(W)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_run     (cfg_run),
  .cfg_aux_mode(cfg_aux_mode),
  .wr_core_en  (wr_core_en),
  .wr_core_data(wr_core_data),
  .wr_aux_en   (wr_aux_en),
  .wr_aux_data (wr_aux_data),
  .core_q      (core_q),
  .aux_q       (aux_q),
  .tgl_out     (tgl_out),
  .irq         (irq)
);

// File: tb/test_gp_timer_unit.sv
module test_gp_timer_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_run = 1'b0;
  logic [1:0]  cfg_mode = 2'd0;
  logic [2:0]  cfg_pre = 3'd0;
  logic        cfg_dir_down = 1'b0;
  logic        cfg_ext_dir_en = 1'b0;
  logic [1:0]  cfg_edge = 2'd0;
  logic [1:0]  cfg_aux_mode = 2'd0;
  logic [1:0]  cfg_cap_edge = 2'd0;
  logic        wr_core_en = 1'b0;
  logic [15:0] wr_core_data = '0;
  logic        wr_aux_en = 1'b0;
  logic [15:0] wr_aux_data = '0;
  logic        pin_tin = 1'b0;
  logic        pin_dir = 1'b0;
  logic        pin_cap = 1'b0;
  logic [15:0] core_q, aux_q;
  logic        tgl_out, irq;

  int checks = 0;
  int errors = 0;
  logic exp_tgl = 1'b0;

  always #10 clk = ~clk;

  gp_timer_unit i_gp_timer_unit (.*);

  // edge_sel, down, pulses, start, expected, wraps
  typedef struct packed {
    logic [1:0]  edge_sel;
    logic        down;
    logic [3:0]  pulses;
    logic [15:0] start;
    logic [15:0] exp_val;
    logic        wraps;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{2'b01, 1'b0, 4'd5, 16'd10,     16'd15,     1'b0},
    '{2'b10, 1'b0, 4'd3, 16'd0,      16'd3,      1'b0},
    '{2'b11, 1'b0, 4'd4, 16'd100,    16'd108,    1'b0},
    '{2'b01, 1'b1, 4'd2, 16'd1,      16'hFFFF,   1'b1},
    '{2'b11, 1'b1, 4'd3, 16'd3,      16'hFFFD,   1'b1},
    '{2'b01, 1'b0, 4'd2, 16'hFFFF,   16'd1,      1'b1},
    '{2'b00, 1'b0, 4'd4, 16'd7,      16'd7,      1'b0}
  };

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_core(input logic [15:0] v);
    wr_core_en = 1'b1; wr_core_data = v;
    cyc(1);
    wr_core_en = 1'b0;
  endtask

  task automatic wr_aux(input logic [15:0] v);
    wr_aux_en = 1'b1; wr_aux_data = v;
    cyc(1);
    wr_aux_en = 1'b0;
  endtask

  task automatic pulse_tin(input int n);
    for (int k = 0; k < n; k++) begin
      pin_tin = 1'b1; cyc(4);
      pin_tin = 1'b0; cyc(4);
    end
  endtask

  task automatic quad_to(input logic a, input logic b);
    pin_tin = a; pin_dir = b;
    cyc(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    cyc(3);
    // R1 reset state
    chk("R1 core", 32'(core_q), 32'h0);
    chk("R1 aux", 32'(aux_q), 32'h0);
    chk("R1 tgl", 32'(tgl_out), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    rst_n = 1'b1;
    cyc(2);

    // R4 R5 R6 vector walk in event mode
    cfg_mode = 2'd2;
    cfg_run  = 1'b1;
    foreach (VECS[i]) begin
      cfg_edge     = VECS[i].edge_sel;
      cfg_dir_down = VECS[i].down;
      wr_core(VECS[i].start);
      cyc(2);
      pulse_tin(int'(VECS[i].pulses));
      if (VECS[i].wraps) exp_tgl = ~exp_tgl;
      chk($sformatf("R4 R5 row %0d count", i), 32'(core_q), 32'(VECS[i].exp_val));
      chk($sformatf("R6 row %0d toggle", i), 32'(tgl_out), 32'(exp_tgl));
    end
    cfg_dir_down = 1'b0;

    // R11 stopped: event pulses ignored
    cfg_run = 1'b0; cfg_edge = 2'b11;
    wr_core(16'h0042);
    pulse_tin(2);
    chk("R11 stopped", 32'(core_q), 32'h0042);

    // R5 external direction pin
    cfg_run = 1'b1; cfg_edge = 2'b01; cfg_ext_dir_en = 1'b1; pin_dir = 1'b1;
    wr_core(16'd10);
    cyc(4);
    pulse_tin(2);
    chk("R5 pin down", 32'(core_q), 32'd8);
    cfg_ext_dir_en = 1'b0;
    pulse_tin(2);
    chk("R5 software up", 32'(core_q), 32'd10);
    pin_dir = 1'b0;
    cyc(4);

    // R2 timer mode, divide by 8
    cfg_run = 1'b0; cfg_mode = 2'd0; cfg_pre = 3'd0;
    wr_core(16'd0);
    cfg_run = 1'b1;
    cyc(39);
    chk("R2 before fifth tick", 32'(core_q), 32'd4);
    cyc(1);
    chk("R2 fifth tick", 32'(core_q), 32'd5);

    // R2 divide by 32
    cfg_run = 1'b0; cfg_pre = 3'd2;
    wr_core(16'd0);
    cfg_run = 1'b1;
    cyc(63);
    chk("R2 pre2 early", 32'(core_q), 32'd1);
    cyc(1);
    chk("R2 pre2 second tick", 32'(core_q), 32'd2);

    // R3 gated mode
    cfg_run = 1'b0; cfg_pre = 3'd0; cfg_mode = 2'd1; pin_tin = 1'b0;
    wr_core(16'd0);
    cyc(4);
    cfg_run = 1'b1;
    cyc(32);
    chk("R3 gate closed", 32'(core_q), 32'd0);
    cfg_run = 1'b0; pin_tin = 1'b1;
    cyc(4);
    cfg_run = 1'b1;
    cyc(16);
    chk("R3 gate open", 32'(core_q), 32'd2);
    cfg_run = 1'b0; pin_tin = 1'b0;
    cyc(4);

    // R10 CPU write beats a divider tick in the same cycle
    cfg_mode = 2'd0;
    wr_core(16'd0);
    cfg_run = 1'b1;
    cyc(7);
    wr_core(16'h0100);
    chk("R10 write over tick", 32'(core_q), 32'h0100);
    cyc(8);
    chk("R10 next tick", 32'(core_q), 32'h0101);
    cfg_run = 1'b0;

    // R7 quadrature
    cfg_mode = 2'd3; cfg_run = 1'b1;
    wr_core(16'd0);
    cyc(4);
    quad_to(1'b1, 1'b0); quad_to(1'b1, 1'b1); quad_to(1'b0, 1'b1); quad_to(1'b0, 1'b0);
    chk("R7 forward", 32'(core_q), 32'd4);
    quad_to(1'b0, 1'b1); quad_to(1'b1, 1'b1); quad_to(1'b1, 1'b0); quad_to(1'b0, 1'b0);
    chk("R7 reverse", 32'(core_q), 32'd0);
    quad_to(1'b1, 1'b1); quad_to(1'b0, 1'b0);
    chk("R7 double change ignored", 32'(core_q), 32'd0);
    cfg_dir_down = 1'b1;
    quad_to(1'b1, 1'b0);
    chk("R7 inverted", 32'(core_q), 32'hFFFF);
    exp_tgl = ~exp_tgl;
    quad_to(1'b0, 1'b0);
    chk("R7 inverted back", 32'(core_q), 32'd0);
    exp_tgl = ~exp_tgl;
    cfg_dir_down = 1'b0;

    // R8 reload on overflow, R6 irq, R12 latency
    cfg_mode = 2'd2; cfg_edge = 2'b01; cfg_aux_mode = 2'b01;
    wr_aux(16'hFFF0);
    wr_core(16'hFFFF);
    cyc(2);
    pin_tin = 1'b1;
    cyc(2);
    chk("R12 no early step", 32'(core_q), 32'hFFFF);
    cyc(1);
    exp_tgl = ~exp_tgl;
    chk("R8 reload value", 32'(core_q), 32'hFFF0);
    chk("R6 irq high", 32'(irq), 32'h1);
    chk("R6 toggle", 32'(tgl_out), 32'(exp_tgl));
    cyc(1);
    chk("R6 irq one cycle", 32'(irq), 32'h0);
    pin_tin = 1'b0;
    cyc(4);

    // R9 capture
    cfg_run = 1'b0; cfg_aux_mode = 2'b10; cfg_cap_edge = 2'b01;
    wr_core(16'h1234);
    pin_cap = 1'b1;
    cyc(3);
    chk("R9 capture rise", 32'(aux_q), 32'h1234);
    wr_core(16'h5678);
    pin_cap = 1'b0;
    cyc(4);
    chk("R9 falling ignored", 32'(aux_q), 32'h1234);
    cfg_cap_edge = 2'b11;
    pin_cap = 1'b1;
    cyc(4);
    chk("R9 both edges", 32'(aux_q), 32'h5678);
    pin_cap = 1'b0;
    cyc(4);

    // R10 aux write beats a capture in the same cycle
    cfg_cap_edge = 2'b01;
    wr_core(16'h0AAA);
    pin_cap = 1'b1;
    cyc(2);
    wr_aux(16'hBEEF);
    chk("R10 aux write over capture", 32'(aux_q), 32'hBEEF);
    cyc(2);
    chk("R10 aux held", 32'(aux_q), 32'hBEEF);

    finish_run();
  end
endmodule